// File: doc/BRIEF.md
# Stacked Register Frame Allocator

This unit keeps the current frame of the stacked general registers. Logical registers below a fixed static count are plain static registers. Logical registers from that count upward belong to a stacked window. A frame is made of three consecutive regions, placed in this order: inputs, then locals, then outputs. Inputs and locals together form the local region. All three together form the frame. A stacked reference past the last output register is illegal. A legal stacked reference is translated to a physical register by adding a base offset, modulo the size of the physical pool.

The unit takes three commands.
- **Allocate** sets new region sizes and a rotating count. It also hands the previous-frame descriptor to a destination register through a save port.
- **Call** slides the base past the caller's local region, so that the caller's outputs become the callee's first registers.
- **Return** takes a saved descriptor, restores the frame from it, and moves the base back.

Nothing is spilled to memory. When a request needs more physical registers than the callers leave free, the unit reports an overflow and leaves the frame as it was. A separate access port translates and checks one logical register per cycle.

Top module: `rsf_frame_alloc`

## Requirements
- R1: After reset the frame is empty, the base and the caller depth are zero, and the saved descriptor is zero. `cmdReady`, `saveValid` and `accDone` are low, and every stacked access faults.
- R2: A logical register below STATIC_REGS never faults. Its physical number equals its logical number.
- R3: Let off = logical − STATIC_REGS for a stacked access. The access faults when off ≥ frame size. Otherwise `accPhys` = STATIC_REGS + ((off + base) mod POOL_REGS). `accDone`, `accFault` and `accPhys` are valid in the cycle after `accValid`.
- R4: An allocate is an error, and leaves all state unchanged, in any of these cases:
  - inputs+locals+outputs > POOL_REGS;
  - the rotating count exceeds that sum;
  - the destination is register 0;
  - the destination is a stacked register outside the new frame.
- R5: An allocate that is not an error, and whose frame size exceeds POOL_REGS − depth, raises `cmdOverflow` and leaves all state unchanged. Here depth is the sum of the callers' local regions.
- R6: A successful allocate sets local size = inputs+locals and frame size = inputs+locals+outputs, so the outputs start at logical STATIC_REGS+inputs+locals. It pulses `saveValid` with `saveData` equal to the saved descriptor and `saveReg` equal to the destination mapped under the new frame. The descriptor layout is: frame size in bits [CNT_W-1:0], local size in [2*CNT_W-1:CNT_W], rotating count in [3*CNT_W-1:2*CNT_W].
- R7: A call saves the current descriptor and advances the base by the local size, modulo POOL_REGS. It adds the local size to depth and leaves a frame of size (frame − local), with zero local and rotating counts.
- R8: A return loads the frame from `cmdDesc`, moves the base back by the descriptor's local size, and subtracts that size from depth. It is an error, with no state change, if any of these holds:
  - local > frame;
  - rotating > frame;
  - frame > POOL_REGS;
  - local > depth;
  - the restored frame does not fit the free pool.
- R9: Every command cycle gives exactly one `cmdReady` pulse in the next cycle. `cmdError` and `cmdOverflow` appear only with it and never together.
- R10: `cmdOp` encoding: 0 allocate, 1 call, 2 return. Code 3 is reserved; it is acknowledged as an error and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmdValid | input | 1 | Command strobe |
| cmdOp | input | 2 | Command code (R10) |
| cmdIn | input | CNT_W | Input register count |
| cmdLoc | input | CNT_W | Local register count |
| cmdOut | input | CNT_W | Output register count |
| cmdRot | input | CNT_W | Rotating register count |
| cmdDest | input | LREG_W | Logical destination for the saved descriptor |
| cmdDesc | input | 3*CNT_W | Descriptor restored by a return |
| accValid | input | 1 | Access strobe |
| accReg | input | LREG_W | Logical register to translate |
| cmdReady | output | 1 | Command completion pulse |
| cmdError | output | 1 | Invalid command |
| cmdOverflow | output | 1 | Physical pool exhausted |
| saveValid | output | 1 | Saved descriptor write strobe |
| saveReg | output | LREG_W | Physical destination of the saved descriptor |
| saveData | output | 3*CNT_W | Saved descriptor |
| accDone | output | 1 | Access result valid |
| accFault | output | 1 | Illegal register reference |
| accPhys | output | LREG_W | Physical register number |

## Verification
The bench builds the unit with STATIC_REGS = 32 and POOL_REGS = 16. With these values the logical index is six bits wide, so each access sweep covers every logical number from 0 to 63, including every fault position past the frame. A 16-entry pool is small enough that every frame size up to and past the limit is swept for allocate validity. It also lets short call chains fill the pool completely, which reaches the overflow case and the case where the base wraps to zero while depth equals the pool.

// File: rtl/rsf_pkg.sv
package rsf_pkg;

  typedef enum logic [1:0] {
    OP_ALLOC = 2'd0,
    OP_CALL  = 2'd1,
    OP_RET   = 2'd2,
    OP_RSVD  = 2'd3
  } frameOp_e;

  // strobes from control to datapath for one command cycle
  typedef struct packed {
    logic ack;
    logic fault;
    logic overflow;
    logic applyAlloc;
    logic applyCall;
    logic applyRet;
  } frameStrobes_t;

endpackage

// File: rtl/rsf_ctrl.sv
module rsf_ctrl
  import rsf_pkg::*;
#(
  parameter int STATIC_REGS = 32,
  parameter int POOL_REGS   = 96,
  parameter int LREG_W      = 7,
  parameter int CNT_W       = 7
) (
  input  logic                 cmdValid,
  input  logic [1:0]           cmdOp,
  input  logic [CNT_W-1:0]     cmdIn,
  input  logic [CNT_W-1:0]     cmdLoc,
  input  logic [CNT_W-1:0]     cmdOut,
  input  logic [CNT_W-1:0]     cmdRot,
  input  logic [LREG_W-1:0]    cmdDest,
  input  logic [3*CNT_W-1:0]   cmdDesc,
  input  logic [CNT_W-1:0]     curSof,
  input  logic [CNT_W-1:0]     curSol,
  input  logic [CNT_W-1:0]     depth,
  output frameStrobes_t        strobes,
  output logic [CNT_W-1:0]     nextSof,
  output logic [CNT_W-1:0]     nextSol,
  output logic [CNT_W-1:0]     nextSor
);

  localparam int AW = ((LREG_W > CNT_W) ? LREG_W : CNT_W) + 3;

  frameOp_e       op;
  logic [AW-1:0]  allocSof, allocSol, rotW, destW, depthW, poolW, staticW;
  logic [AW-1:0]  retSof, retSol, retSor, freeAfterRet;
  logic           destBad, allocBad, allocOvf, retBad;

  assign op       = frameOp_e'(cmdOp);
  assign poolW    = AW'(POOL_REGS);
  assign staticW  = AW'(STATIC_REGS);
  assign depthW   = AW'(depth);
  assign rotW     = AW'(cmdRot);
  assign destW    = AW'(cmdDest);
  assign allocSol = AW'(cmdIn) + AW'(cmdLoc);
  assign allocSof = allocSol + AW'(cmdOut);

  assign retSof = AW'(cmdDesc[CNT_W-1:0]);
  assign retSol = AW'(cmdDesc[2*CNT_W-1:CNT_W]);
  assign retSor = AW'(cmdDesc[3*CNT_W-1:2*CNT_W]);

  // destination: never the zero register, and a stacked target must sit in the new frame
  assign destBad  = (destW == '0) ||
                    ((destW >= staticW) && ((destW - staticW) >= allocSof));
  assign allocBad = (allocSof > poolW) || (rotW > allocSof) || destBad;
  assign allocOvf = allocSof > (poolW - depthW);

  assign freeAfterRet = poolW - (depthW - retSol);
  assign retBad = (retSol > retSof) || (retSor > retSof) || (retSof > poolW) ||
                  (retSol > depthW) || (retSof > freeAfterRet);

  always_comb begin
    strobes     = '0;
    strobes.ack = cmdValid;
    nextSof     = CNT_W'(allocSof);
    nextSol     = CNT_W'(allocSol);
    nextSor     = cmdRot;
    if (cmdValid) begin
      unique case (op)
        OP_ALLOC: begin
          if (allocBad)      strobes.fault      = 1'b1;
          else if (allocOvf) strobes.overflow   = 1'b1;
          else               strobes.applyAlloc = 1'b1;
        end
        OP_CALL: begin
          strobes.applyCall = 1'b1;
          nextSof = curSof - curSol;
          nextSol = '0;
          nextSor = '0;
        end
        OP_RET: begin
          nextSof = CNT_W'(retSof);
          nextSol = CNT_W'(retSol);
          nextSor = CNT_W'(retSor);
          if (retBad) strobes.fault     = 1'b1;
          else        strobes.applyRet  = 1'b1;
        end
        default: strobes.fault = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/rsf_data.sv
module rsf_data
  import rsf_pkg::*;
#(
  parameter int STATIC_REGS = 32,
  parameter int POOL_REGS   = 96,
  parameter int LREG_W      = 7,
  parameter int CNT_W       = 7
) (
  input  logic                 clk,
  input  logic                 rst,
  input  frameStrobes_t        strobes,
  input  logic [CNT_W-1:0]     nextSof,
  input  logic [CNT_W-1:0]     nextSol,
  input  logic [CNT_W-1:0]     nextSor,
  input  logic [LREG_W-1:0]    cmdDest,
  input  logic                 accValid,
  input  logic [LREG_W-1:0]    accReg,
  output logic [CNT_W-1:0]     curSof,
  output logic [CNT_W-1:0]     curSol,
  output logic [CNT_W-1:0]     depth,
  output logic                 cmdReady,
  output logic                 cmdError,
  output logic                 cmdOverflow,
  output logic                 saveValid,
  output logic [LREG_W-1:0]    saveReg,
  output logic [3*CNT_W-1:0]   saveData,
  output logic                 accDone,
  output logic                 accFault,
  output logic [LREG_W-1:0]    accPhys
);

  localparam int AW = ((LREG_W > CNT_W) ? LREG_W : CNT_W) + 3;

  logic [CNT_W-1:0] curSor, base;
  logic [CNT_W-1:0] prevSof, prevSol, prevSor;
  logic [CNT_W-1:0] baseCall, baseRet, depthCall, depthRet;
  logic             accMiss;

  // logical -> physical under base b; static registers pass through
  function automatic logic [LREG_W-1:0] mapReg(input logic [LREG_W-1:0] lreg,
                                               input logic [CNT_W-1:0]  b);
    logic [AW-1:0] off;
    logic [AW-1:0] sum;
    if (AW'(lreg) < AW'(STATIC_REGS)) return lreg;
    off = AW'(lreg) - AW'(STATIC_REGS);
    sum = off + AW'(b);
    if (sum >= AW'(POOL_REGS)) sum = sum - AW'(POOL_REGS);
    return LREG_W'(sum + AW'(STATIC_REGS));
  endfunction

  always_comb begin
    logic [AW-1:0] t;
    t = AW'(base) + AW'(curSol);
    if (t >= AW'(POOL_REGS)) t = t - AW'(POOL_REGS);
    baseCall  = CNT_W'(t);
    depthCall = CNT_W'(AW'(depth) + AW'(curSol));
    if (base >= nextSol) baseRet = base - nextSol;
    else                 baseRet = CNT_W'(AW'(base) + AW'(POOL_REGS) - AW'(nextSol));
    depthRet = depth - nextSol;
  end

  assign accMiss = (AW'(accReg) >= AW'(STATIC_REGS)) &&
                   ((AW'(accReg) - AW'(STATIC_REGS)) >= AW'(curSof));

  always_ff @(posedge clk) begin
    if (rst) begin
      curSof <= '0; curSol <= '0; curSor <= '0;
      prevSof <= '0; prevSol <= '0; prevSor <= '0;
      base <= '0; depth <= '0;
      cmdReady <= 1'b0; cmdError <= 1'b0; cmdOverflow <= 1'b0;
      saveValid <= 1'b0; saveReg <= '0; saveData <= '0;
      accDone <= 1'b0; accFault <= 1'b0; accPhys <= '0;
    end else begin
      cmdReady    <= strobes.ack;
      cmdError    <= strobes.fault;
      cmdOverflow <= strobes.overflow;
      saveValid   <= strobes.applyAlloc;
      accDone     <= accValid;
      accFault    <= accValid && accMiss;
      accPhys     <= (accValid && !accMiss) ? mapReg(accReg, base) : '0;
      if (strobes.applyAlloc) begin
        curSof   <= nextSof;
        curSol   <= nextSol;
        curSor   <= nextSor;
        saveReg  <= mapReg(cmdDest, base);
        saveData <= {prevSor, prevSol, prevSof};
      end
      if (strobes.applyCall) begin
        prevSof <= curSof;
        prevSol <= curSol;
        prevSor <= curSor;
        curSof  <= nextSof;
        curSol  <= nextSol;
        curSor  <= nextSor;
        base    <= baseCall;
        depth   <= depthCall;
      end
      if (strobes.applyRet) begin
        curSof <= nextSof;
        curSol <= nextSol;
        curSor <= nextSor;
        base   <= baseRet;
        depth  <= depthRet;
      end
    end
  end

endmodule

// File: rtl/rsf_frame_alloc.sv
module rsf_frame_alloc
  import rsf_pkg::*;
#(
  parameter int STATIC_REGS = 32,
  parameter int POOL_REGS   = 96,
  localparam int LREG_W     = $clog2(STATIC_REGS + POOL_REGS),
  localparam int CNT_W      = $clog2(POOL_REGS + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cmdValid,
  input  logic [1:0]           cmdOp,
  input  logic [CNT_W-1:0]     cmdIn,
  input  logic [CNT_W-1:0]     cmdLoc,
  input  logic [CNT_W-1:0]     cmdOut,
  input  logic [CNT_W-1:0]     cmdRot,
  input  logic [LREG_W-1:0]    cmdDest,
  input  logic [3*CNT_W-1:0]   cmdDesc,
  input  logic                 accValid,
  input  logic [LREG_W-1:0]    accReg,
  output logic                 cmdReady,
  output logic                 cmdError,
  output logic                 cmdOverflow,
  output logic                 saveValid,
  output logic [LREG_W-1:0]    saveReg,
  output logic [3*CNT_W-1:0]   saveData,
  output logic                 accDone,
  output logic                 accFault,
  output logic [LREG_W-1:0]    accPhys
);

  frameStrobes_t    strobes;
  logic [CNT_W-1:0] nextSof, nextSol, nextSor;
  logic [CNT_W-1:0] curSof, curSol, depth;

  rsf_ctrl #(
    .STATIC_REGS(STATIC_REGS), .POOL_REGS(POOL_REGS),
    .LREG_W(LREG_W), .CNT_W(CNT_W)
  ) u_ctrl (
    .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdIn(cmdIn), .cmdLoc(cmdLoc), .cmdOut(cmdOut), .cmdRot(cmdRot),
    .cmdDest(cmdDest), .cmdDesc(cmdDesc),
    .curSof(curSof), .curSol(curSol), .depth(depth),
    .strobes(strobes), .nextSof(nextSof), .nextSol(nextSol), .nextSor(nextSor)
  );

  rsf_data #(
    .STATIC_REGS(STATIC_REGS), .POOL_REGS(POOL_REGS),
    .LREG_W(LREG_W), .CNT_W(CNT_W)
  ) u_data (
    .clk(clk), .rst(rst), .strobes(strobes),
    .nextSof(nextSof), .nextSol(nextSol), .nextSor(nextSor),
    .cmdDest(cmdDest), .accValid(accValid), .accReg(accReg),
    .curSof(curSof), .curSol(curSol), .depth(depth),
    .cmdReady(cmdReady), .cmdError(cmdError), .cmdOverflow(cmdOverflow),
    .saveValid(saveValid), .saveReg(saveReg), .saveData(saveData),
    .accDone(accDone), .accFault(accFault), .accPhys(accPhys)
  );

endmodule

// File: rtl/rsf_frame_alloc_chk.sv
module rsf_frame_alloc_chk #(
  parameter int STATIC_REGS = 32,
  parameter int POOL_REGS   = 96,
  parameter int LREG_W      = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              cmdValid,
  input logic              accValid,
  input logic [LREG_W-1:0] accReg,
  input logic              cmdReady,
  input logic              cmdError,
  input logic              cmdOverflow,
  input logic              saveValid,
  input logic              accDone,
  input logic              accFault,
  input logic [LREG_W-1:0] accPhys
);

  p_ack_follows_cmd_r9: assert property (@(posedge clk) disable iff (rst)
    cmdValid |=> cmdReady);

  p_no_ack_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !cmdValid |=> !cmdReady);

  p_flags_with_ack_r9: assert property (@(posedge clk) disable iff (rst)
    (cmdError || cmdOverflow) |-> (cmdReady && !(cmdError && cmdOverflow)));

  p_save_only_on_success_r6: assert property (@(posedge clk) disable iff (rst)
    saveValid |-> (cmdReady && !cmdError && !cmdOverflow));

  p_static_passthrough_r2: assert property (@(posedge clk) disable iff (rst)
    (accValid && int'(accReg) < STATIC_REGS) |=>
      (accDone && !accFault && accPhys == $past(accReg)));

  p_phys_in_pool_r3: assert property (@(posedge clk) disable iff (rst)
    (accDone && !accFault) |-> (int'(accPhys) < STATIC_REGS + POOL_REGS));

  p_fault_with_done_r3: assert property (@(posedge clk) disable iff (rst)
    accFault |-> accDone);

endmodule

bind rsf_frame_alloc rsf_frame_alloc_chk #(
  .STATIC_REGS(STATIC_REGS), .POOL_REGS(POOL_REGS), .LREG_W(LREG_W)
) u_chk (
  .clk(clk), .rst(rst), .cmdValid(cmdValid), .accValid(accValid), .accReg(accReg),
  .cmdReady(cmdReady), .cmdError(cmdError), .cmdOverflow(cmdOverflow),
  .saveValid(saveValid), .accDone(accDone), .accFault(accFault), .accPhys(accPhys)
);

// File: tb/test_rsf_frame_alloc.sv
module test_rsf_frame_alloc;

  localparam int SREGS = 32;
  localparam int POOL  = 16;
  localparam int LW    = 6;
  localparam int CW    = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmdValid = 1'b0;
  logic [1:0] cmdOp = '0;
  logic [CW-1:0] cmdIn = '0, cmdLoc = '0, cmdOut = '0, cmdRot = '0;
  logic [LW-1:0] cmdDest = '0;
  logic [3*CW-1:0] cmdDesc = '0;
  logic accValid = 1'b0;
  logic [LW-1:0] accReg = '0;
  logic cmdReady, cmdError, cmdOverflow, saveValid, accDone, accFault;
  logic [LW-1:0] saveReg, accPhys;
  logic [3*CW-1:0] saveData;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  // reference model state
  int mSof, mSol, mSor, mBase, mDepth, pSof, pSol, pSor;

  rsf_frame_alloc #(.STATIC_REGS(SREGS), .POOL_REGS(POOL)) i_rsf_frame_alloc (
    .clk(clk), .rst(rst), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdIn(cmdIn), .cmdLoc(cmdLoc), .cmdOut(cmdOut), .cmdRot(cmdRot),
    .cmdDest(cmdDest), .cmdDesc(cmdDesc), .accValid(accValid), .accReg(accReg),
    .cmdReady(cmdReady), .cmdError(cmdError), .cmdOverflow(cmdOverflow),
    .saveValid(saveValid), .saveReg(saveReg), .saveData(saveData),
    .accDone(accDone), .accFault(accFault), .accPhys(accPhys)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL R9 watchdog: act=hung exp=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int pack(input int sof, input int sol, input int sor);
    return sof + (sol << CW) + (sor << (2*CW));
  endfunction

  function automatic int mapL(input int l);
    if (l < SREGS) return l;
    return SREGS + ((l - SREGS + mBase) % POOL);
  endfunction

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    mSof = 0; mSol = 0; mSor = 0; mBase = 0; mDepth = 0;
    pSof = 0; pSol = 0; pSor = 0;
  endtask

  task automatic access(input int l);
    int expFault;
    @(negedge clk);
    accValid = 1'b1;
    accReg   = LW'(l);
    @(negedge clk);
    accValid = 1'b0;
    expFault = (l >= SREGS && (l - SREGS) >= mSof) ? 1 : 0;
    chk((l < SREGS) ? "R2 done" : "R3 done", int'(accDone), 1);
    chk((l < SREGS) ? "R2 fault" : "R3 fault", int'(accFault), expFault);
    if (expFault == 0)
      chk((l < SREGS) ? "R2 phys" : "R3 phys", int'(accPhys), mapL(l));
  endtask

  task automatic sweep();
    for (int l = 0; l < (1 << LW); l++) access(l);
  endtask

  // generic command with expectations computed from the requirements
  task automatic command(input int op, input int i, input int lo, input int o,
                         input int r, input int dest, input int desc);
    int sof, eErr, eOvf, eSave, eSaveReg, eSaveData;
    int dSof, dSol, dSor;
    @(negedge clk);
    cmdValid = 1'b1;
    cmdOp = 2'(op);
    cmdIn = CW'(i); cmdLoc = CW'(lo); cmdOut = CW'(o); cmdRot = CW'(r);
    cmdDest = LW'(dest); cmdDesc = (3*CW)'(desc);
    @(negedge clk);
    cmdValid = 1'b0;
    eErr = 0; eOvf = 0; eSave = 0; eSaveReg = 0; eSaveData = 0;
    if (op == 0) begin
      sof = i + lo + o;
      eErr = (sof > POOL || r > sof || dest == 0 ||
              (dest >= SREGS && dest - SREGS >= sof)) ? 1 : 0;
      eOvf = (!eErr && sof > POOL - mDepth) ? 1 : 0;
      if (!eErr && !eOvf) begin
        eSave = 1;
        eSaveData = pack(pSof, pSol, pSor);
        mSof = sof; mSol = i + lo; mSor = r;
        eSaveReg = mapL(dest);
      end
    end else if (op == 1) begin
      pSof = mSof; pSol = mSol; pSor = mSor;
      mBase = (mBase + mSol) % POOL;
      mDepth = mDepth + mSol;
      mSof = mSof - mSol; mSol = 0; mSor = 0;
    end else if (op == 2) begin
      dSof = desc & ((1 << CW) - 1);
      dSol = (desc >> CW) & ((1 << CW) - 1);
      dSor = (desc >> (2*CW)) & ((1 << CW) - 1);
      eErr = (dSol > dSof || dSor > dSof || dSof > POOL || dSol > mDepth ||
              dSof > POOL - (mDepth - dSol)) ? 1 : 0;
      if (!eErr) begin
        mSof = dSof; mSol = dSol; mSor = dSor;
        mBase = (mBase - dSol + POOL) % POOL;
        mDepth = mDepth - dSol;
      end
    end else begin
      eErr = 1;  // R10 reserved code
    end
    chk("R9 ready", int'(cmdReady), 1);
    chk((op == 3) ? "R10 error" : ((op == 2) ? "R8 error" : "R4 error"),
        int'(cmdError), eErr);
    chk("R5 overflow", int'(cmdOverflow), eOvf);
    chk("R6 saveValid", int'(saveValid), eSave);
    if (eSave != 0) begin
      chk("R6 saveReg", int'(saveReg), eSaveReg);
      chk("R6 saveData", int'(saveData), eSaveData);
    end
    @(negedge clk);
    chk("R9 single pulse", int'(cmdReady), 0);
  endtask

  initial begin
    doReset();
    // R1: idle outputs and empty frame after reset
    chk("R1 ready", int'(cmdReady), 0);
    chk("R1 saveValid", int'(saveValid), 0);
    chk("R1 accDone", int'(accDone), 0);
    access(SREGS);       // R1: stacked access faults
    access(7);           // R2
    sweep();

    // R4/R6/R3: allocate sweep from an empty caller chain
    for (int i = 0; i < 6; i++)
      for (int lo = 0; lo < 6; lo++)
        for (int o = 0; o < 8; o += 2) begin
          int sof, k, r, dest;
          sof = i + lo + o;
          k = (i + lo + o / 2) % 3;
          r = (k == 0) ? 0 : ((k == 1) ? sof : sof + 1);
          if (((o / 2) % 2) == 1) dest = 1 + i;
          else dest = (sof == 0) ? SREGS : SREGS + sof - 1;
          command(0, i, lo, o, r, dest, 0);
          sweep();
        end
    command(0, 9, 4, 4, 0, 1, 0);     // R4: sum above pool
    command(0, 1, 1, 1, 0, 0, 0);     // R4: destination zero register
    sweep();

    // R6/R7/R5/R8: call chain
    doReset();
    command(0, 2, 4, 3, 0, 1, 0);     // R6: outputs start at logical 38
    access(38);
    access(40);
    access(41);
    command(1, 0, 0, 0, 0, 0, 0);     // R7 call
    sweep();
    command(0, 3, 2, 2, 0, 33, 0);    // R6: saved descriptor of caller
    sweep();
    command(0, 3, 3, 5, 0, 1, 0);     // R5: 11 > 16-6
    sweep();
    command(1, 0, 0, 0, 0, 0, 0);     // R7 nested call
    sweep();
    command(2, 0, 0, 0, 0, 0, pack(7, 5, 0));   // R8 return one level
    sweep();
    command(2, 0, 0, 0, 0, 0, pack(9, 6, 0));   // R8 return to top
    sweep();
    command(2, 0, 0, 0, 0, 0, pack(9, 6, 0));   // R8: local > depth
    command(2, 0, 0, 0, 0, 0, pack(4, 5, 0));   // R8: local > frame
    command(3, 1, 1, 1, 0, 1, 0);               // R10 reserved
    sweep();

    // R5/R7/R8: whole pool held by the caller
    command(0, 16, 0, 0, 0, 1, 0);
    command(1, 0, 0, 0, 0, 0, 0);
    access(SREGS);                              // R5 context: empty frame
    command(0, 0, 0, 1, 0, 1, 0);               // R5 overflow
    command(0, 0, 0, 0, 0, 2, 0);               // R6 empty frame allocate
    command(2, 0, 0, 0, 0, 0, pack(16, 16, 0)); // R8 restore
    sweep();

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule